// File: doc/BRIEF.md
# Multi-Channel Compare Event Timer

This block is a register-mapped event timer. A single free-running 32-bit main counter ticks once per clock while the global enable is set. Three comparator channels watch it. Each channel raises an interrupt when the counter reaches its match value. A channel fires either once, and then waits to be rearmed by a new comparator write, or periodically, moving its match value forward by a programmed step after every hit.

Software reaches every register through a plain 32-bit read/write port with byte addresses. Read data returns one cycle after the read strobe. A channel's interrupt is either held, with a status bit that software clears by writing 1, or sent as a one-cycle pulse. The interrupt goes to one of 32 output lines chosen by the channel's route field. A global legacy-routing switch overrides that choice for channels 0 and 1.

Top module: `evt_timer_hub`

## Requirements
- R1: Capability word (0x000) reads vendor in [31:16], legacy-capable flag 1 in [15], counter-size flag 0 in [13], channel count minus one in [12:8] and revision in [7:0]. Tick-period word (0x004) reads the tick period in femtoseconds (default 10,000,000). Reset values: global config (0x010) 0, status (0x020) 0, counter (0x0F0) 0, channel config 0x110, all interrupt lines low.
- R2: Global config bit 0 enables the counter, which then adds 1 every clock. With the bit clear the counter holds. The counter can be written directly.
- R3: A one-shot channel (config bit 3 clear) fires once when the counter equals its comparator (channel base +8). It does not fire again until the comparator is rewritten.
- R4: With periodic mode (bit 3) and set-value (bit 6) set, the first comparator write loads the match value and the next loads the step. Bit 6 reads 1 between these writes and 0 after the step write.
- R5: A periodic channel fires on every counter value match, match+step, match+2*step, and so on.
- R6: Matching is exact equality on 32 bits and still works when the counter wraps past 0xFFFFFFFF.
- R7: In level mode (config bit 1 = 1) a fire sets the channel's bit (bit index = channel number) in the status word, and the routed line stays high while it is set. Writing 1 clears the bit; writing 0 has no effect.
- R8: In edge mode (bit 1 = 0) each fire gives a one-cycle high on the routed line and leaves the status bit clear.
- R9: The route field in bits 13:9 selects the output line. With global config bit 1 set, channel 0 drives line 0 and channel 1 drives line 8, whatever their route fields hold.
- R10: Clearing interrupt enable (bit 2) and periodic mode stops all further interrupts from that channel.
- R11: The word at channel base +4 reads a fixed route mask and ignores writes. Channel bases are 0x100, 0x120, 0x140.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| irq_out | output | 32 | Interrupt output lines |

## Verification
The counter value matches in the cycle that follows n edges after the enable write, where n is the comparator minus the start value taken modulo 2^32. The routed line rises one edge after that, so the bench samples at falling edges exactly n+1 cycles after the enable write: low one cycle earlier, high at that point, and low again one cycle later in edge mode. Register writes take effect at the write edge and reads return at the next falling edge. For the random periodic trials, the pulse count expected over a fixed window is computed from the start value, match value and step.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int ADDR_W    = 12;
  localparam int ROUTE_W   = 5;
  localparam int IRQ_N     = 1 << ROUTE_W;
  localparam logic [ADDR_W-1:0] A_CAPS   = 12'h000;
  localparam logic [ADDR_W-1:0] A_PERIOD = 12'h004;
  localparam logic [ADDR_W-1:0] A_GCFG   = 12'h010;
  localparam logic [ADDR_W-1:0] A_STAT   = 12'h020;
  localparam logic [ADDR_W-1:0] A_CNT    = 12'h0F0;
  localparam int CH_BASE   = 'h100;
  localparam int CH_STRIDE = 'h20;
  localparam int CH_CFG    = 0;
  localparam int CH_MASK   = 4;
  localparam int CH_CMP    = 8;
  // channel config bit positions
  localparam int B_LEVEL   = 1;
  localparam int B_IEN     = 2;
  localparam int B_PER     = 3;
  localparam int B_PERCAP  = 4;
  localparam int B_SIZE    = 5;
  localparam int B_SETVAL  = 6;
  localparam int B_F32     = 8;
  localparam int B_ROUTE   = 9;
  // global config bit positions
  localparam int G_EN      = 0;
  localparam int G_LEGACY  = 1;

  function automatic logic [ADDR_W-1:0] ch_addr(input int ch, input int off);
    return ADDR_W'(CH_BASE + ch * CH_STRIDE + off);
  endfunction
endpackage

// File: rtl/evt_main_counter.sv
module evt_main_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (wr)      cnt_d = wdata;
    else if (en) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  p_hold_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !wr) |=> $stable(cnt_q));
  p_step_when_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wr) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/evt_channel.sv
module evt_channel
  import evt_pkg::*;
#(
  parameter int   CNT_W   = 32,
  parameter bit   PER_CAP = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cnt_en,
  input  logic [CNT_W-1:0]   cnt,
  input  logic               cfg_wr,
  input  logic               cmp_wr,
  input  logic [31:0]        wdata,
  input  logic               stat_clr,
  output logic [31:0]        cfg_rd,
  output logic [CNT_W-1:0]   cmp_rd,
  output logic               status,
  output logic               line,
  output logic               pulse,
  output logic [ROUTE_W-1:0] route
);
  logic level_q, level_d, ien_q, ien_d, per_q, per_d;
  logic setval_q, setval_d, phase_q, phase_d, armed_q, armed_d;
  logic status_q, status_d, pulse_q, pulse_d;
  logic [ROUTE_W-1:0] route_q, route_d;
  logic [CNT_W-1:0]   cmp_q, cmp_d, step_q, step_d;
  logic match, fire;

  assign match = cnt_en && armed_q && (cnt == cmp_q);
  assign fire  = match && ien_q;

  always_comb begin
    level_d  = level_q;
    ien_d    = ien_q;
    per_d    = per_q;
    setval_d = setval_q;
    phase_d  = phase_q;
    route_d  = route_q;
    cmp_d    = cmp_q;
    step_d   = step_q;
    armed_d  = armed_q;
    if (cfg_wr) begin
      level_d = wdata[B_LEVEL];
      ien_d   = wdata[B_IEN];
      per_d   = wdata[B_PER] & PER_CAP;
      route_d = wdata[B_ROUTE +: ROUTE_W];
      if (wdata[B_SETVAL]) begin
        setval_d = 1'b1;
        phase_d  = 1'b0;
      end
    end
    if (match) begin
      if (per_q) cmp_d   = cmp_q + step_q;
      else       armed_d = 1'b0;
    end
    if (cmp_wr) begin
      if (per_q && setval_q) begin
        if (!phase_q) begin
          cmp_d   = wdata[CNT_W-1:0];
          phase_d = 1'b1;
          armed_d = 1'b1;
        end else begin
          step_d   = wdata[CNT_W-1:0];
          setval_d = 1'b0;
          phase_d  = 1'b0;
        end
      end else begin
        cmp_d   = wdata[CNT_W-1:0];
        armed_d = 1'b1;
      end
    end
    status_d = status_q;
    if (fire && level_q) status_d = 1'b1;
    else if (stat_clr)   status_d = 1'b0;
    pulse_d = fire && !level_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q  <= 1'b0;
      ien_q    <= 1'b0;
      per_q    <= 1'b0;
      setval_q <= 1'b0;
      phase_q  <= 1'b0;
      route_q  <= '0;
      cmp_q    <= '0;
      step_q   <= '0;
      armed_q  <= 1'b0;
      status_q <= 1'b0;
      pulse_q  <= 1'b0;
    end else begin
      level_q  <= level_d;
      ien_q    <= ien_d;
      per_q    <= per_d;
      setval_q <= setval_d;
      phase_q  <= phase_d;
      route_q  <= route_d;
      cmp_q    <= cmp_d;
      step_q   <= step_d;
      armed_q  <= armed_d;
      status_q <= status_d;
      pulse_q  <= pulse_d;
    end
  end

  always_comb begin
    cfg_rd                        = '0;
    cfg_rd[B_LEVEL]               = level_q;
    cfg_rd[B_IEN]                 = ien_q;
    cfg_rd[B_PER]                 = per_q;
    cfg_rd[B_PERCAP]              = PER_CAP;
    cfg_rd[B_SIZE]                = 1'b0;
    cfg_rd[B_SETVAL]              = setval_q;
    cfg_rd[B_F32]                 = 1'b1;
    cfg_rd[B_ROUTE +: ROUTE_W]    = route_q;
  end

  assign cmp_rd = cmp_q;
  assign status = status_q;
  assign line   = status_q;
  assign pulse  = pulse_q;
  assign route  = route_q;

  p_periodic_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (match && per_q && !cmp_wr) |=> (cmp_q == $past(cmp_q) + $past(step_q)));
  p_oneshot_disarm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !per_q && !cmp_wr) |=> !armed_q);
  p_status_only_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q) |-> $past(level_q));
  p_w1c_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !fire) |=> !status_q);
endmodule

// File: rtl/evt_irq_router.sv
module evt_irq_router
  import evt_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic [NUM_CH-1:0]              line,
  input  logic [NUM_CH-1:0]              pulse,
  input  logic [NUM_CH-1:0][ROUTE_W-1:0] route,
  input  logic                           legacy,
  output logic [IRQ_N-1:0]               irq
);
  logic [ROUTE_W-1:0] dest;

  always_comb begin
    irq  = '0;
    dest = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      dest = route[c];
      if (legacy && c == 0) dest = ROUTE_W'(0);
      if (legacy && c == 1) dest = ROUTE_W'(8);
      irq[dest] = irq[dest] | line[c] | pulse[c];
    end
  end
endmodule

// File: rtl/evt_timer_hub.sv
module evt_timer_hub
  import evt_pkg::*;
#(
  parameter int          NUM_CH     = 3,
  parameter logic [15:0] VENDOR     = 16'h1D0A,
  parameter logic [7:0]  REV        = 8'h02,
  parameter int          TICK_FS    = 10_000_000,
  parameter logic [31:0] ROUTE_MASK = 32'h00F0_1F3C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [11:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [31:0]       irq_out
);
  localparam int CNT_W = 32;
  localparam logic [31:0] CAPS_WORD =
    {VENDOR, 1'b1, 1'b0, 1'b0, 5'(NUM_CH - 1), REV};

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  logic wr_stb, rd_stb;
  assign wr_stb = bus_sel && bus_wr;
  assign rd_stb = bus_sel && !bus_wr;

  // global configuration
  logic en_q, en_d, legacy_q, legacy_d;
  always_comb begin
    en_d     = en_q;
    legacy_d = legacy_q;
    if (wr_stb && bus_addr == A_GCFG) begin
      en_d     = bus_wdata[G_EN];
      legacy_d = bus_wdata[G_LEGACY];
    end
  end
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      en_q     <= 1'b0;
      legacy_q <= 1'b0;
    end else begin
      en_q     <= en_d;
      legacy_q <= legacy_d;
    end
  end

  // main counter
  logic [CNT_W-1:0] cnt;
  logic             cnt_wr;
  assign cnt_wr = wr_stb && bus_addr == A_CNT;
  evt_main_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_q), .en(en_q), .wr(cnt_wr),
    .wdata(bus_wdata), .cnt(cnt)
  );

  // channels
  logic [NUM_CH-1:0]              ch_status, ch_line, ch_pulse;
  logic [NUM_CH-1:0][ROUTE_W-1:0] ch_route;
  logic [NUM_CH-1:0][31:0]        ch_cfg_rd, ch_cmp_rd;
  logic                           stat_wr;
  assign stat_wr = wr_stb && bus_addr == A_STAT;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic cfg_wr_g, cmp_wr_g, clr_g;
    assign cfg_wr_g = wr_stb && bus_addr == ch_addr(g, CH_CFG);
    assign cmp_wr_g = wr_stb && bus_addr == ch_addr(g, CH_CMP);
    assign clr_g    = stat_wr && bus_wdata[g];
    evt_channel #(.CNT_W(CNT_W), .PER_CAP(1'b1)) u_chan (
      .clk(clk), .rst_n(rst_q), .cnt_en(en_q), .cnt(cnt),
      .cfg_wr(cfg_wr_g), .cmp_wr(cmp_wr_g), .wdata(bus_wdata),
      .stat_clr(clr_g), .cfg_rd(ch_cfg_rd[g]), .cmp_rd(ch_cmp_rd[g]),
      .status(ch_status[g]), .line(ch_line[g]), .pulse(ch_pulse[g]),
      .route(ch_route[g])
    );
  end

  evt_irq_router #(.NUM_CH(NUM_CH)) u_router (
    .line(ch_line), .pulse(ch_pulse), .route(ch_route),
    .legacy(legacy_q), .irq(irq_out)
  );

  // read path
  logic [31:0] rd_mux, rdata_q, rdata_d;
  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_CAPS:   rd_mux = CAPS_WORD;
      A_PERIOD: rd_mux = 32'(TICK_FS);
      A_GCFG:   rd_mux = {30'b0, legacy_q, en_q};
      A_STAT:   rd_mux = 32'(ch_status);
      A_CNT:    rd_mux = cnt;
      default:  rd_mux = '0;
    endcase
    for (int c = 0; c < NUM_CH; c++) begin
      if (bus_addr == ch_addr(c, CH_CFG))  rd_mux = ch_cfg_rd[c];
      if (bus_addr == ch_addr(c, CH_MASK)) rd_mux = ROUTE_MASK;
      if (bus_addr == ch_addr(c, CH_CMP))  rd_mux = ch_cmp_rd[c];
    end
  end
  always_comb rdata_d = rd_stb ? rd_mux : rdata_q;
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end
  assign bus_rdata = rdata_q;

  p_legacy_ch0_r9: assert property (@(posedge clk) disable iff (!rst_q)
    (legacy_q && ch_line[0]) |-> irq_out[0]);
  p_legacy_ch1_r9: assert property (@(posedge clk) disable iff (!rst_q)
    (legacy_q && NUM_CH > 1 && ch_line[NUM_CH > 1 ? 1 : 0]) |-> irq_out[8]);
  p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_q)
    (ch_line == '0 && ch_pulse == '0) |-> (irq_out == '0));
endmodule

// File: tb/test_evt_timer_hub.sv
`timescale 1ns/1ps
module test_evt_timer_hub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, irq;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  localparam logic [31:0] LEVEL = 32'h2, IEN = 32'h4, PER = 32'h8, SETV = 32'h40;

  always #2.5 clk = ~clk;

  evt_timer_hub i_evt_timer_hub (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_out(irq)
  );

  function automatic logic [11:0] cha(input int ch, input int off);
    return 12'(32'h100 + ch * 32 + off);
  endfunction
  function automatic logic [31:0] cfgw(input logic [31:0] bits, input int rt);
    return bits | (32'(rt) << 9);
  endfunction
  // pulses seen over negedges 1..n after the enable write, first match d ticks away
  function automatic int exp_pulses(input logic [31:0] d, input int s, input int n);
    if (d > 32'(n - 1)) return 0;
    return (n - 1 - int'(d)) / s + 1;
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [11:0] a, input logic [31:0] d);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bread(input logic [11:0] a, output logic [31:0] d);
    sel = 1'b1; wr = 1'b0; addr = a;
    @(negedge clk);
    sel = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_line(input int ln, input int n, output int cnt);
    cnt = 0;
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      if (irq[ln]) cnt++;
    end
  endtask

  task automatic quiesce();
    bwrite(12'h010, 32'h0);
    for (int c = 0; c < 3; c++) bwrite(cha(c, 0), 32'h0);
    bwrite(12'h020, 32'h7);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] r;
    int n, e;
    void'($urandom(32'd20240611));
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state and identification
    bread(12'h000, r); check(r, 32'h1D0A_8202, "R1 caps");
    bread(12'h004, r); check(r, 32'd10_000_000, "R1 period");
    bread(12'h010, r); check(r, 32'h0, "R1 gcfg reset");
    bread(12'h020, r); check(r, 32'h0, "R1 status reset");
    bread(12'h0F0, r); check(r, 32'h0, "R1 counter reset");
    bread(cha(2, 0), r); check(r, 32'h110, "R1 chan cfg reset");
    check(irq, 32'h0, "R1 lines low");

    // R11 route mask is read-only
    bwrite(cha(1, 4), 32'hFFFF_FFFF);
    bread(cha(1, 4), r); check(r, 32'h00F0_1F3C, "R11 route mask");

    // R2 counter enable, hold and write
    bwrite(12'h0F0, 32'd100);
    idle(5);
    bread(12'h0F0, r); check(r, 32'd100, "R2 hold while off");
    bwrite(12'h010, 32'h1);
    idle(10);
    bread(12'h0F0, r); check(r, 32'd110, "R2 counts when on");
    bwrite(12'h010, 32'h0);
    bread(12'h0F0, r);
    idle(6);
    begin
      logic [31:0] r2;
      bread(12'h0F0, r2); check(r2, r, "R2 stops when off");
    end

    // R3/R8 one-shot edge, exact cycle
    quiesce();
    bwrite(12'h0F0, 32'd0);
    bwrite(cha(0, 0), cfgw(IEN, 5));
    bwrite(cha(0, 8), 32'd20);
    bwrite(12'h010, 32'h1);
    idle(20); check(32'(irq[5]), 0, "R3 not before match");
    idle(1);  check(32'(irq[5]), 1, "R3 fires at match");
    idle(1);  check(32'(irq[5]), 0, "R8 one-cycle pulse");
    bread(12'h020, r); check(r, 32'h0, "R8 edge leaves status clear");
    count_line(5, 30, n); check(32'(n), 0, "R3 no second fire");
    bwrite(12'h010, 32'h0);
    bwrite(12'h0F0, 32'd10);
    bwrite(12'h010, 32'h1);
    count_line(5, 20, n); check(32'(n), 0, "R3 disarmed after fire");
    bwrite(12'h010, 32'h0);
    bwrite(12'h0F0, 32'd10);
    bwrite(cha(0, 8), 32'd15);
    bwrite(12'h010, 32'h1);
    count_line(5, 20, n); check(32'(n), 1, "R3 rearm by comparator write");

    // R6 wrap
    quiesce();
    bwrite(12'h0F0, 32'hFFFF_FFF8);
    bwrite(cha(1, 0), cfgw(IEN, 17));
    bwrite(cha(1, 8), 32'd4);
    bwrite(12'h010, 32'h1);
    idle(12); check(32'(irq[17]), 0, "R6 not before wrapped match");
    idle(1);  check(32'(irq[17]), 1, "R6 fires across wrap");

    // R7/R9 level mode and route
    quiesce();
    bwrite(12'h0F0, 32'd0);
    bwrite(cha(2, 0), cfgw(IEN | LEVEL, 12));
    bwrite(cha(2, 8), 32'd3);
    bwrite(12'h010, 32'h1);
    idle(10);
    check(32'(irq[12]), 1, "R7 level held");
    bread(12'h020, r); check(r, 32'h4, "R7 status bit");
    bwrite(12'h020, 32'h0);
    check(32'(irq[12]), 1, "R7 write 0 no effect on line");
    bread(12'h020, r); check(r, 32'h4, "R7 write 0 no effect");
    bwrite(12'h020, 32'h4);
    check(32'(irq[12]), 0, "R7 write 1 clears line");
    bread(12'h020, r); check(r, 32'h0, "R7 write 1 clears");

    // R9 legacy override
    quiesce();
    bwrite(12'h0F0, 32'd0);
    bwrite(cha(0, 0), cfgw(IEN | LEVEL, 7));
    bwrite(cha(1, 0), cfgw(IEN | LEVEL, 3));
    bwrite(cha(0, 8), 32'd5);
    bwrite(cha(1, 8), 32'd5);
    bwrite(12'h010, 32'h3);
    idle(10);
    check(irq, 32'h0000_0101, "R9 legacy lines 0 and 8");
    quiesce();
    bwrite(12'h0F0, 32'd0);
    bwrite(cha(1, 0), cfgw(IEN | LEVEL, 3));
    bwrite(cha(1, 8), 32'd5);
    bwrite(12'h010, 32'h1);
    idle(10);
    check(irq, 32'h0000_0008, "R9 route field without legacy");

    // R4 set-value sequence
    quiesce();
    bwrite(12'h0F0, 32'd0);
    bwrite(cha(0, 0), cfgw(PER | SETV | IEN, 2));
    bread(cha(0, 0), r); check(r & SETV, SETV, "R4 set-value armed");
    bwrite(cha(0, 8), 32'd6);
    bread(cha(0, 0), r); check(r & SETV, SETV, "R4 set-value held after first write");
    bwrite(cha(0, 8), 32'd4);
    bread(cha(0, 0), r); check(r & SETV, 32'h0, "R4 set-value cleared after step");
    bread(cha(0, 8), r); check(r, 32'd6, "R4 first write is match value");
    bwrite(12'h010, 32'h1);
    count_line(2, 30, n); check(32'(n), 32'(exp_pulses(6, 4, 30)), "R5 periodic count");

    // R10 stop
    bwrite(cha(0, 0), 32'h0);
    count_line(2, 40, n); check(32'(n), 0, "R10 stopped channel silent");

    // R5/R6 random periodic trials
    for (int t = 0; t < 10; t++) begin
      int ch, rt, s;
      logic [31:0] v, d;
      ch = int'($urandom_range(0, 2));
      rt = int'($urandom_range(0, 31));
      s  = int'($urandom_range(1, 15));
      d  = 32'($urandom_range(0, 40));
      v  = $urandom;
      quiesce();
      bwrite(12'h0F0, v);
      bwrite(cha(ch, 0), cfgw(PER | SETV | IEN, rt));
      bwrite(cha(ch, 8), v + d);
      bwrite(cha(ch, 8), 32'(s));
      bwrite(12'h010, 32'h1);
      count_line(rt, 60, e);
      check(32'(e), 32'(exp_pulses(d, s, 60)), "R5 random periodic");
    end
    bread(12'h020, r); check(r, 32'h0, "R8 edge trials leave status clear");

    done = 1'b1;
    finish_run();
  end
endmodule